// File: doc/BRIEF.md
# Recursive Cosine Oscillator

This block produces a one-sided cosine sequence in fixed point. It uses a second-order recursion with a feed-forward term on the delayed input. A signed Q1.15 coefficient `c` sets the frequency. `c` is the cosine of the per-sample angular step, and that step is 2π·f0/fs with f0 kept below fs/2. A start pulse clears every delayed value and captures the coefficient. After that, the block emits one signed sample for each accepted sample strobe, and `out_valid` marks each new sample.

The recursion is y[n] = 2c·y[n-1] − y[n-2] + x[n] − c·x[n-1]. Each sample takes two multiplications (2c·y[n-1] and c·x[n-1]) and three additions or subtractions. The block generates its own excitation. x[n] is a full-scale impulse on the first strobe after a start and zero afterwards, so the output is the impulse response A·cos(ω0·n). The delayed outputs carry extra fractional bits and two bits of integer headroom. The next state is clamped rather than allowed to wrap, and the output is rounded and clamped to a symmetric 16-bit range.

A small controller sequences the datapath. Its states are:
- `ST_IDLE`: after reset; strobes are ignored.
- `ST_ARMED`: state cleared; the next strobe applies the impulse.
- `ST_RUN`: free-running recursion with zero input.

Its transitions are:
- `start` moves any state to `ST_ARMED`.
- An accepted strobe moves `ST_ARMED` to `ST_RUN`.
- `ST_RUN` holds on further strobes.
- `start` has priority over a strobe in the same cycle.

Top module: `rcos_osc`

## Requirements
- R1: After reset, and in the cycle after any `start`, `out_valid` is 0 and `out_sample` is 0. Strobes given before the first `start` produce no `out_valid`.
- R2: The first accepted strobe after `start` yields exactly `IMPULSE_AMP` (default 32767) on `out_sample`.
- R3: The second sample equals round(A·c) within ±1 LSB, where A = `IMPULSE_AMP` and c = coef/32768.
- R4: Sample n (counting from 0) matches round(A·cos(n·acos(c))) within ±3 LSB for at least 300 samples, for any |coef| ≤ 31784.
- R5: `out_valid` is high for exactly one cycle, in the cycle after each accepted strobe, and low at all other times.
- R6: `out_sample` keeps its value while no strobe and no `start` occur.
- R7: A second `start` with the same coefficient reproduces the earlier sequence bit for bit.
- R8: The coefficient is captured only at `start`. Changes on `coef` during a run do not alter the sequence.
- R9: The output is clamped to ±32767 and never shows −32768. With coef = −32768 (c = −1) the output alternates +32767 and −32767 exactly.
- R10: With coef = 0 (quarter sample rate) the output is exactly A, 0, −A, 0, … repeating.
- R11: When `start` and `step_en` are high in the same cycle, no sample is produced. The next strobe yields the impulse value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clears state, captures `coef`, arms the impulse |
| step_en | input | 1 | Sample strobe; one output sample per accepted strobe |
| coef | input | COEF_W | Signed Q1.15 cosine of the angular step |
| out_sample | output | DATA_W | Signed output sample, symmetric clamp |
| out_valid | output | 1 | One-cycle flag for a new sample |

## Verification
The state is fed back, so a corrupted delayed output, delayed input or coefficient shows on `out_sample` in the cycle after the next strobe. It also persists as a lasting phase or amplitude error rather than a one-off glitch. Comparing every sample against a cosine evaluated in double precision exposes such faults within one or two samples. Exact cases (c = −1, c = 0, the first sample, restart) catch rounding and sign faults that a tolerance would otherwise hide. Controller faults appear immediately as a missing or extra `out_valid`, or as a sample that changes between strobes.

// File: rtl/osc_pkg.sv
package osc_pkg;

    // Sequencer states of the oscillator
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } osc_state_e;

endpackage

// File: rtl/osc_ctrl.sv
module osc_ctrl
    import osc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       step_en,
    output osc_state_e state_q,
    output logic       clr_o,
    output logic       adv_o,
    output logic       imp_o
);

    osc_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic: start wins over a strobe in the same cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (start)        state_d = ST_ARMED;
                else if (step_en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (start) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Control outputs to the datapath
    always_comb begin
        clr_o = start;
        adv_o = step_en && !start && (state_q != ST_IDLE);
        imp_o = (state_q == ST_ARMED);
    end

endmodule

// File: rtl/osc_core.sv
module osc_core #(
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter int FRAC_EXT    = 12,
    parameter int STATE_W     = 30,
    parameter int IMPULSE_AMP = 32767
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      adv,
    input  logic                      imp_sel,
    input  logic signed [COEF_W-1:0]  coef,
    output logic signed [COEF_W-1:0]  coef_lat,
    output logic signed [STATE_W-1:0] y_next
);

    // Derived widths
    localparam int C2W = COEF_W + 1;          // room for 2c
    localparam int PW  = STATE_W + C2W;       // full product width
    localparam int EXT = 4;                   // guard bits for the sum
    localparam int AW  = STATE_W + EXT;       // accumulator width
    localparam int SH  = COEF_W - 1;          // Q1.15 scaling shift

    localparam logic signed [PW-1:0]      RND   = PW'(longint'(1) <<< (SH - 1));
    localparam logic signed [AW-1:0]      LIM_A = AW'((longint'(1) <<< (STATE_W - 1)) - longint'(1));
    localparam logic signed [STATE_W-1:0] LIM_S = STATE_W'((longint'(1) <<< (STATE_W - 1)) - longint'(1));
    localparam logic signed [STATE_W-1:0] IMP_S = STATE_W'(longint'(IMPULSE_AMP) <<< FRAC_EXT);

    // Stored coefficients and history
    logic signed [COEF_W-1:0]  c_q;
    logic signed [C2W-1:0]     c2_q;
    logic signed [STATE_W-1:0] y1_q;
    logic signed [STATE_W-1:0] y2_q;
    logic signed [STATE_W-1:0] x1_q;

    // Datapath intermediates
    logic signed [STATE_W-1:0] x_cur;
    logic signed [PW-1:0]      prod_fb;
    logic signed [PW-1:0]      prod_ff;
    logic signed [PW-1:0]      scl_fb;
    logic signed [PW-1:0]      scl_ff;
    logic signed [AW-1:0]      term_fb;
    logic signed [AW-1:0]      term_ff;
    logic signed [AW-1:0]      y2_ext;
    logic signed [AW-1:0]      x_ext;
    logic signed [AW-1:0]      acc;

    assign coef_lat = c_q;

    // Internal excitation: impulse on the armed sample, zero afterwards
    always_comb begin
        x_cur = imp_sel ? IMP_S : '0;
    end

    // Two multiplications, rounded back to state scale
    always_comb begin
        prod_fb = PW'(c2_q) * PW'(y1_q);
        prod_ff = PW'(c_q)  * PW'(x1_q);
        scl_fb  = (prod_fb + RND) >>> SH;
        scl_ff  = (prod_ff + RND) >>> SH;
        term_fb = scl_fb[AW-1:0];
        term_ff = scl_ff[AW-1:0];
    end

    // Three add/subtract operations at extended width
    always_comb begin
        y2_ext = {{EXT{y2_q[STATE_W-1]}}, y2_q};
        x_ext  = {{EXT{x_cur[STATE_W-1]}}, x_cur};
        acc    = term_fb - y2_ext + x_ext - term_ff;
    end

    // Clamp the new state so it never wraps
    always_comb begin
        if (acc > LIM_A) begin
            y_next = LIM_S;
        end else if (acc < -LIM_A) begin
            y_next = -LIM_S;
        end else begin
            y_next = acc[STATE_W-1:0];
        end
    end

    // Coefficient capture and history update
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q  <= '0;
            c2_q <= '0;
            y1_q <= '0;
            y2_q <= '0;
            x1_q <= '0;
        end else if (clr) begin
            c_q  <= coef;
            c2_q <= {coef, 1'b0};
            y1_q <= '0;
            y2_q <= '0;
            x1_q <= '0;
        end else if (adv) begin
            y2_q <= y1_q;
            y1_q <= y_next;
            x1_q <= x_cur;
        end
    end

endmodule

// File: rtl/osc_outq.sv
module osc_outq #(
    parameter int DATA_W   = 16,
    parameter int STATE_W  = 30,
    parameter int FRAC_EXT = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      adv,
    input  logic signed [STATE_W-1:0] y_next,
    output logic signed [DATA_W-1:0]  out_sample,
    output logic                      out_valid
);

    localparam int EW = STATE_W + 1;
    localparam logic signed [EW-1:0] OMAX = EW'((longint'(1) <<< (DATA_W - 1)) - longint'(1));

    logic signed [EW-1:0]     ext;
    logic signed [EW-1:0]     scaled;
    logic signed [DATA_W-1:0] sample_d;

    assign ext = {y_next[STATE_W-1], y_next};

    // Drop the fractional extension: round to nearest, or pass straight through
    generate
        if (FRAC_EXT > 0) begin : g_round
            localparam logic signed [EW-1:0] HALF = EW'(longint'(1) <<< (FRAC_EXT - 1));
            always_comb begin
                scaled = (ext + HALF) >>> FRAC_EXT;
            end
        end else begin : g_pass
            always_comb begin
                scaled = ext;
            end
        end
    endgenerate

    // Symmetric clamp to the output word
    always_comb begin
        if (scaled > OMAX) begin
            sample_d = OMAX[DATA_W-1:0];
        end else if (scaled < -OMAX) begin
            sample_d = -OMAX[DATA_W-1:0];
        end else begin
            sample_d = scaled[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else if (clr) begin
            out_sample <= '0;
            out_valid  <= 1'b0;
        end else begin
            out_valid <= adv;
            if (adv) begin
                out_sample <= sample_d;
            end
        end
    end

endmodule

// File: rtl/rcos_osc.sv
module rcos_osc
    import osc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter int FRAC_EXT    = 12,
    parameter int HEADROOM    = 2,
    parameter int IMPULSE_AMP = 32767
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     step_en,
    input  logic signed [COEF_W-1:0] coef,
    output logic signed [DATA_W-1:0] out_sample,
    output logic                     out_valid
);

    localparam int STATE_W = DATA_W + FRAC_EXT + HEADROOM;

    osc_state_e                fsm_st;
    logic                      clr;
    logic                      adv;
    logic                      imp_sel;
    logic signed [COEF_W-1:0]  coef_lat;
    logic signed [STATE_W-1:0] y_next;

    osc_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .step_en (step_en),
        .state_q (fsm_st),
        .clr_o   (clr),
        .adv_o   (adv),
        .imp_o   (imp_sel)
    );

    osc_core #(
        .DATA_W      (DATA_W),
        .COEF_W      (COEF_W),
        .FRAC_EXT    (FRAC_EXT),
        .STATE_W     (STATE_W),
        .IMPULSE_AMP (IMPULSE_AMP)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .imp_sel  (imp_sel),
        .coef     (coef),
        .coef_lat (coef_lat),
        .y_next   (y_next)
    );

    osc_outq #(
        .DATA_W   (DATA_W),
        .STATE_W  (STATE_W),
        .FRAC_EXT (FRAC_EXT)
    ) u_outq (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr),
        .adv        (adv),
        .y_next     (y_next),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );

endmodule

// File: rtl/osc_chk.sv
module osc_chk
    import osc_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int COEF_W      = 16,
    parameter int IMPULSE_AMP = 32767
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     step_en,
    input logic signed [DATA_W-1:0] out_sample,
    input logic                     out_valid,
    input osc_state_e               fsm_st,
    input logic signed [COEF_W-1:0] coef_lat
);

    localparam logic signed [DATA_W-1:0] AMP_W = DATA_W'(IMPULSE_AMP);
    localparam logic signed [DATA_W-1:0] MIN_W = {1'b1, {(DATA_W-1){1'b0}}};

    // R1
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!out_valid && out_sample == '0));

    // R5
    valid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(step_en) && !$past(start) && $past(fsm_st) != ST_IDLE));

    // R5
    strobe_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !start && fsm_st != ST_IDLE) |=> out_valid);

    // R6
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !start) |=> $stable(out_sample));

    // R2
    impulse_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_st == ST_ARMED && step_en && !start) |=> (out_sample == AMP_W));

    // R8
    coef_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(coef_lat));

    // R9
    no_min_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sample != MIN_W));

endmodule

bind rcos_osc osc_chk #(
    .DATA_W      (DATA_W),
    .COEF_W      (COEF_W),
    .IMPULSE_AMP (IMPULSE_AMP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step_en    (step_en),
    .out_sample (out_sample),
    .out_valid  (out_valid),
    .fsm_st     (fsm_st),
    .coef_lat   (coef_lat)
);

// File: tb/rcos_osc_tb.sv
`timescale 1ns/1ps
module rcos_osc_tb;

    localparam int AMP = 32767;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               step_en = 1'b0;
    logic signed [15:0] coef = '0;
    logic signed [15:0] out_sample;
    logic               out_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    rcos_osc u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .step_en    (step_en),
        .coef       (coef),
        .out_sample (out_sample),
        .out_valid  (out_valid)
    );

    function automatic int rnd(real r);
        if (r >= 0.0) return $rtoi(r + 0.5);
        return -$rtoi(-r + 0.5);
    endfunction

    function automatic int clamp16(int v);
        if (v > AMP)  return AMP;
        if (v < -AMP) return -AMP;
        return v;
    endfunction

    // Expected sample n of the cosine impulse response for coefficient cf
    function automatic int ref_sample(int cf, int n);
        real c = real'(cf) / 32768.0;
        real w = $acos(c);
        return clamp16(rnd(real'(AMP) * $cos(w * real'(n))));
    endfunction

    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; pulses start for one cycle
    task automatic kick(int cf);
        coef  = cf[15:0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!out_valid && out_sample == 16'sd0, "R1", int'(out_sample), 0);
    endtask

    // One strobe, then gap idle cycles checking hold and valid
    task automatic step(int gap, output int s);
        step_en = 1'b1;
        @(negedge clk);
        step_en = 1'b0;
        check(out_valid, "R5", int'(out_valid), 1);
        s = int'(out_sample);
        check(s != -32768, "R9", s, -32767);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(!out_valid, "R5", int'(out_valid), 0);
            check(int'(out_sample) == s, "R6", int'(out_sample), s);
        end
    endtask

    task automatic run_ref(int cf, int first, int count, int tol, string req);
        int s;
        for (int n = first; n < first + count; n++) begin
            step(int'($urandom_range(2, 0)), s);
            check(iabs(s - ref_sample(cf, n)) <= tol, req, s, ref_sample(cf, n));
        end
    endtask

    initial begin
        int s;
        int s1;
        int cf;
        int rec[64];
        void'($urandom(32'd8675309));

        repeat (4) @(negedge clk);
        // R1: reset state
        check(!out_valid && out_sample == 16'sd0, "R1", int'(out_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: strobes before any start give nothing
        step_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(!out_valid, "R1", int'(out_valid), 0);
        end
        step_en = 1'b0;
        @(negedge clk);

        // R2 and R9: c = -1 alternates full scale exactly
        kick(-32768);
        step(1, s);
        check(s == AMP, "R2", s, AMP);
        for (int n = 1; n < 20; n++) begin
            step(0, s);
            check(s == ((n % 2) ? -AMP : AMP), "R9", s, (n % 2) ? -AMP : AMP);
        end

        // R10: quarter rate exact
        kick(0);
        run_ref(0, 0, 16, 0, "R10");

        // R3: second sample equals round(A*c)
        kick(12345);
        step(0, s);
        check(s == AMP, "R2", s, AMP);
        step(0, s1);
        check(iabs(s1 - rnd(real'(AMP) * 12345.0 / 32768.0)) <= 1, "R3", s1,
              rnd(real'(AMP) * 12345.0 / 32768.0));

        // R4: random coefficients against the cosine reference
        for (int k = 0; k < 6; k++) begin
            cf = int'($urandom_range(63568, 0)) - 31784;
            kick(cf);
            run_ref(cf, 0, 300, 3, "R4");
        end
        // R4: directed edges of the allowed range
        kick(31784);
        run_ref(31784, 0, 300, 3, "R4");
        kick(-31784);
        run_ref(-31784, 0, 300, 3, "R4");

        // R7: restart reproduces the sequence bit for bit
        cf = 23170;
        kick(cf);
        for (int n = 0; n < 64; n++) begin
            step(0, s);
            rec[n] = s;
        end
        kick(cf);
        for (int n = 0; n < 64; n++) begin
            step(1, s);
            check(s == rec[n], "R7", s, rec[n]);
        end

        // R8: coefficient changes mid-run are ignored
        kick(20000);
        run_ref(20000, 0, 10, 3, "R8");
        coef = -16'sd5000;
        run_ref(20000, 10, 100, 3, "R8");

        // R11: start and strobe together give no sample, then impulse
        coef    = 16'sd9000;
        start   = 1'b1;
        step_en = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        step_en = 1'b0;
        check(!out_valid, "R11", int'(out_valid), 0);
        step(0, s);
        check(s == AMP, "R11", s, AMP);
        step(0, s1);
        check(iabs(s1 - ref_sample(9000, 1)) <= 1, "R11", s1, ref_sample(9000, 1));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule